// File: doc/BRIEF.md
# Byte-Wide SPI Port with Master and Slave Roles

This block is a full-duplex serial peripheral interface port that sits on a simple CPU bus. Software reaches it through three registers: control, status and data. In the master role, a write to the data register starts an 8-bit exchange. The block makes the serial clock from the system clock through a divider of 4, 16, 64 or 128. It shifts the written byte out on its data-out pin and, at the same time, shifts a byte in from its data-in pin.

In the slave role the block follows a serial clock that comes in from outside. The clock, the slave select and the incoming data each pass through a synchronizer first. The block answers only while it is selected, unless a control bit tells it to ignore the select pin. When a byte ends, the received byte goes to a read buffer and a completion flag is set, which raises the interrupt request. A data write made while an exchange is running is dropped, and a collision flag records it.

Every pin has its own output value and output enable. Pin multiplexing is left to the surrounding chip.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, all three pin output enables are 0 and `irq` is 0.
- R2: In the master role the rate field, control bits [1:0], divides the system clock by 4, 16, 64 or 128 for codes 0 to 3. A byte takes 16 half-periods, so the completion flag is set exactly 32, 128, 512 or 1024 clocks after the clock edge that takes the data write.
- R3: With the enable bit set and control bit 4 = 1 (master), `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. With control bit 4 = 0 (slave), `sck_oe` and `mosi_oe` are 0.
- R4: The enable bit is control bit 6. While it is 0, all pin output enables are 0 and a data write starts no exchange.
- R5: The completion flag is status bit 7. It is set when a byte ends and is cleared by writing 1 to that bit. `irq` equals the completion flag AND the enable bit.
- R6: The collision flag is status bit 6. It is set by a data write (address 2) made while an exchange is running, and it is cleared by writing 1 to that bit. The colliding byte is discarded and the running exchange carries on unchanged.
- R7: A slave is selected when `ss_n_i` is low or when the select-ignore bit, control bit 7, is 1. An unselected slave has `miso_oe` = 0 and ignores clock edges.
- R8: The exchange is full duplex. The byte written to address 2 is sent, and the byte received is read back from address 2.
- R9: Control bit 5 = 1 sends and receives LSB first. When it is 0, MSB first.
- R10: Control bit 3 is the clock polarity. A master's `sck_o` rests at that level whenever no exchange is running.
- R11: Control bit 2 is the clock phase. When it is 0, data is sampled on the first clock edge of each bit. When it is 1, data is sampled on the second edge and driven on the first.
- R12: In the slave role the port shifts on the external clock, sends the byte preloaded at address 2 on `miso_o`, and sets the completion flag after 16 clock edges.
- R13: If a slave is deselected partway through a byte, the partial byte is abandoned: no completion flag is set, and the next selection starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from pin (slave) |
| sck_o | output | 1 | Serial clock to pin (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data from pin (slave) |
| mosi_o | output | 1 | Master-out data to pin |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in data from pin (master) |
| miso_o | output | 1 | Master-in data to pin (slave) |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench builds the port with its default parameters: an 8-bit data width, two synchronizer stages and a 7-bit divider counter. The longest byte is therefore 1024 clocks, so all four rate codes fit in one run, and the bench checks the exact completion cycle for each code. Two synchronizer stages let a bench-driven slave clock with 8-clock half-periods exercise both phases, both polarities, select-ignore, and deselection partway through a byte.

// File: rtl/spi_port_pkg.sv
// Package: shared register addresses, the control-register layout and the
// rate-code decode used by the SPI port.
package spi_port_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_WCOL_BIT = 6;

    // Control register, MSB at the top: select-ignore, enable, order, role,
    // polarity, phase, rate code.
    typedef struct packed {
        logic       ss_ignore;
        logic       en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    // log2 of the half-period in system clocks for each rate code (div/2).
    function automatic int half_log2(input logic [1:0] rate);
        case (rate)
            2'd0:    return 1;
            2'd1:    return 3;
            2'd2:    return 5;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/spi_port_sync.sv
// Module: two-or-more-stage synchronizer for the slave-side pins, plus a
// transition detector on the synchronized serial clock.
// Assumes: STAGES >= 1. All three pins pass through the same number of
// stages, so the data bit stays aligned with the clock edge it belongs to.
module spi_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic mosi_i,
    output logic sck_s,
    output logic ss_n_s,
    output logic mosi_s,
    output logic sck_edge
);
    localparam logic [2:0] RST_VAL = 3'b010;   // {sck, ss_n, mosi}

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [2:0] q;
        if (g == 0) begin : g_first
            // Purpose: first capture stage from the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= {sck_i, ss_n_i, mosi_i};
            end
        end else begin : g_next
            // Purpose: further settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign {sck_s, ss_n_s, mosi_s} = g_stage[STAGES-1].q;

    logic sck_d;

    // Purpose: remember the previous synchronized clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_edge = sck_s ^ sck_d;

endmodule

// File: rtl/spi_port_clkdiv.sv
// Module: half-period tick generator for the master role.
// Assumes: `run` rises in the cycle after an exchange starts. The counter is
// held at 0 while idle, so the first tick comes a full half-period after start.
module spi_port_clkdiv
    import spi_port_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    assign half = CNT_W'(1) << half_log2(rate);
    assign tick = run && (cnt == half - CNT_W'(1));

    // Purpose: count system clocks within one serial half-period.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run||tick) cnt <= '0;
        else                 cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/spi_port_engine.sv
// Module: shift engine shared by both roles. It counts clock edges, samples on
// the phase-selected edge, drives the next bit on the other edge, and reports
// the finished byte.
// Assumes: `load` is raised only when not busy. In the slave role, `edge_in`
// is a transition of the synchronized external clock.
module spi_port_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         master,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         selected,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         start,
    input  logic         tick,
    input  logic         edge_in,
    input  logic         miso_i,
    input  logic         mosi_s,
    output logic         out_bit,
    output logic         phase,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_data
);
    localparam int EC_W = $clog2(2 * W);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * W - 1);

    logic [W-1:0]    sr;
    logic [W-1:0]    sr_next;
    logic [EC_W-1:0] ecnt;
    logic            run;
    logic            rx;
    logic            ev;
    logic            sample;
    logic            last;

    function automatic logic first_bit(input logic [W-1:0] d, input logic lsb);
        return lsb ? d[0] : d[W-1];
    endfunction

    assign rx      = master ? miso_i : mosi_s;
    assign ev      = master ? (run && tick) : (selected && edge_in);
    assign sample  = (ecnt[0] == cpha);
    assign last    = (ecnt == LAST_EDGE);
    assign sr_next = lsb_first ? {rx, sr[W-1:1]} : {sr[W-2:0], rx};
    assign busy    = run || (ecnt != '0);
    assign done    = en && ev && last;
    assign rx_data = sample ? sr_next : sr;

    // Purpose: shift register, edge count, output bit and master clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            ecnt    <= '0;
            run     <= 1'b0;
            phase   <= 1'b0;
            out_bit <= 1'b0;
        end else if (!en) begin
            run   <= 1'b0;
            ecnt  <= '0;
            phase <= 1'b0;
            if (load) begin
                sr      <= load_data;
                out_bit <= first_bit(load_data, lsb_first);
            end
        end else begin
            if (load) begin
                sr      <= load_data;
                out_bit <= first_bit(load_data, lsb_first);
            end
            if (start) run <= 1'b1;
            if (!master && !selected) begin
                ecnt <= '0;
                if (!load) out_bit <= first_bit(sr, lsb_first);
            end else if (ev) begin
                if (master) phase <= ~phase;
                if (sample) sr      <= sr_next;
                else        out_bit <= first_bit(sr, lsb_first);
                if (last) begin
                    ecnt <= '0;
                    run  <= 1'b0;
                end else begin
                    ecnt <= ecnt + EC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spi_port.sv
// Module: SPI port top. It holds the register file and bus decode, the
// completion and collision flags, the read buffer and the pin enables, and
// ties together the synchronizer, the divider and the shift engine.
// Assumes: one-cycle bus strobes and a combinational read path.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_CNT_W   = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq,
    input  logic         sck_i,
    output logic         sck_o,
    output logic         sck_oe,
    input  logic         mosi_i,
    output logic         mosi_o,
    output logic         mosi_oe,
    input  logic         miso_i,
    output logic         miso_o,
    output logic         miso_oe,
    input  logic         ss_n_i
);
    ctrl_t        ctrl_q;
    logic         done_f;
    logic         wcol_f;
    logic [W-1:0] rdbuf;

    logic sck_s, ss_n_s, mosi_s, sck_edge;
    logic tick, out_bit, phase, busy, eng_done;
    logic [W-1:0] rx_data;

    logic cfg_en, cfg_master, cfg_cpol, cfg_ss_ignore, selected;
    logic data_wr, stat_wr, ctrl_wr, load, start;

    assign cfg_en        = ctrl_q.en;
    assign cfg_master    = ctrl_q.master;
    assign cfg_cpol      = ctrl_q.cpol;
    assign cfg_ss_ignore = ctrl_q.ss_ignore;
    assign selected      = cfg_ss_ignore || !ss_n_s;

    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign stat_wr = bus_sel && bus_wr && (bus_addr == ADDR_STAT);
    assign data_wr = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
    assign load    = data_wr && !busy;
    assign start   = load && cfg_en && cfg_master;

    spi_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .ss_n_i   (ss_n_i),
        .mosi_i   (mosi_i),
        .sck_s    (sck_s),
        .ss_n_s   (ss_n_s),
        .mosi_s   (mosi_s),
        .sck_edge (sck_edge)
    );

    spi_port_clkdiv #(.CNT_W(DIV_CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy && cfg_master),
        .rate  (ctrl_q.rate),
        .tick  (tick)
    );

    spi_port_engine #(.W(W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .master    (cfg_master),
        .cpha      (ctrl_q.cpha),
        .lsb_first (ctrl_q.lsb_first),
        .selected  (selected),
        .load      (load),
        .load_data (bus_wdata),
        .start     (start),
        .tick      (tick),
        .edge_in   (sck_edge),
        .miso_i    (miso_i),
        .mosi_s    (mosi_s),
        .out_bit   (out_bit),
        .phase     (phase),
        .busy      (busy),
        .done      (eng_done),
        .rx_data   (rx_data)
    );

    // Purpose: control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata);
    end

    // Purpose: status flags, where a set wins over a write-1 clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f <= 1'b0;
            wcol_f <= 1'b0;
        end else begin
            if (eng_done)                                done_f <= 1'b1;
            else if (stat_wr && bus_wdata[STAT_DONE_BIT]) done_f <= 1'b0;
            if (data_wr && busy)                         wcol_f <= 1'b1;
            else if (stat_wr && bus_wdata[STAT_WCOL_BIT]) wcol_f <= 1'b0;
        end
    end

    // Purpose: capture the finished byte for the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdbuf <= '0;
        else if (eng_done) rdbuf <= rx_data;
    end

    // Purpose: read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = W'(ctrl_q);
            ADDR_STAT: begin
                bus_rdata[STAT_DONE_BIT] = done_f;
                bus_rdata[STAT_WCOL_BIT] = wcol_f;
            end
            ADDR_DATA: bus_rdata = rdbuf;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq     = done_f && cfg_en;
    assign sck_o   = cfg_cpol ^ phase;
    assign mosi_o  = out_bit;
    assign miso_o  = out_bit;
    assign sck_oe  = cfg_en && cfg_master;
    assign mosi_oe = cfg_en && cfg_master;
    assign miso_oe = cfg_en && !cfg_master && selected;

endmodule

// File: rtl/spi_port_chk.sv
// Module: property checker for spi_port, attached with bind below.
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic master,
    input logic cpol,
    input logic ss_ignore,
    input logic ss_n_s,
    input logic busy,
    input logic done_f,
    input logic data_wr,
    input logic wcol_f,
    input logic irq,
    input logic sck_o,
    input logic sck_oe,
    input logic mosi_oe,
    input logic miso_oe
);
    a_r3_master_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master) |-> (sck_oe && mosi_oe && !miso_oe));

    a_r4_disabled_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(sck_oe || mosi_oe || miso_oe));

    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en && done_f));

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_f) |-> $past(busy));

    a_r6_collision_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> wcol_f);

    a_r7_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !master && !ss_ignore && ss_n_s) |-> !miso_oe);

    a_r10_idle_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !busy) |-> (sck_o == cpol));
endmodule

bind spi_port spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .master    (cfg_master),
    .cpol      (cfg_cpol),
    .ss_ignore (cfg_ss_ignore),
    .ss_n_s    (ss_n_s),
    .busy      (busy),
    .done_f    (done_f),
    .data_wr   (data_wr),
    .wcol_f    (wcol_f),
    .irq       (irq),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe)
);

// File: tb/tb_spi_port.sv
// Directed bench for spi_port: one task per scenario, each checking itself.
module tb_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    localparam logic [7:0] C_SSIG = 8'h80, C_EN = 8'h40, C_LSB = 8'h20;
    localparam logic [7:0] C_MST = 8'h10, C_CPOL = 8'h08, C_CPHA = 8'h04;

    always #2 clk = ~clk;   // 250 MHz

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic bitof(input logic [7:0] v, input int i, input logic lsb);
        return lsb ? v[i] : v[7-i];
    endfunction

    function automatic logic [7:0] setbit(input logic [7:0] v, input int i,
                                          input logic lsb, input logic b);
        logic [7:0] r = v;
        if (lsb) r[i] = b; else r[7-i] = b;
        return r;
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 ctrl after reset", v, 0);
        rd(2'd1, v); check("R1 status after reset", v, 0);
        check("R1 enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);
        check("R1 irq after reset", irq, 0);
    endtask

    // Master exchange with a bench slave model; inj > 0 injects a colliding write.
    task automatic t_master(input logic [7:0] ctl, input logic [7:0] tx,
                            input logic [7:0] stx, input int inj);
        logic lsb = ctl[5], cph = ctl[2], prev;
        logic [7:0] got = 8'h00, v;
        int half, cyc = 0, e = 0, ns = 0;
        half = (ctl[1:0] == 2'd0) ? 2 : (ctl[1:0] == 2'd1) ? 8 : (ctl[1:0] == 2'd2) ? 32 : 64;
        wr(2'd0, ctl);
        wr(2'd1, 8'hC0);
        check("R3 master enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
        check("R10 idle clock level", sck_o, ctl[3]);
        miso_i = bitof(stx, 0, lsb);
        wr(2'd2, tx);
        prev = sck_o;
        while (!irq && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (inj > 0 && cyc == inj) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = ~tx;
            end else begin
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
            if (sck_o != prev) begin
                prev = sck_o;
                e++;
                if (((e % 2) == 1) == (cph == 1'b0)) begin
                    if (ns < 8) got = setbit(got, ns, lsb, mosi_o);
                    ns++;
                end else if (ns < 8) begin
                    miso_i = bitof(stx, ns, lsb);
                end
            end
        end
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R2 cycles to completion", cyc, 16 * half);
        check("R11 clock edges per byte", e, 16);
        check("R8 R9 byte seen on mosi", got, tx);
        check("R5 irq at completion", irq, 1);
        check("R10 clock back at rest", sck_o, ctl[3]);
        rd(2'd2, v); check("R8 R9 received byte", v, stx);
        rd(2'd1, v);
        check("R5 done flag", v[7], 1);
        check("R6 collision flag", v[6], (inj > 0) ? 1 : 0);
        wr(2'd1, 8'hC0);
        rd(2'd1, v); check("R5 R6 flags after write-1 clear", v, 0);
        check("R5 irq after clear", irq, 0);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr(2'd0, C_MST);
        wr(2'd2, 8'h11);
        repeat (60) @(negedge clk);
        check("R4 enables while disabled", {sck_oe, mosi_oe, miso_oe}, 0);
        rd(2'd1, v); check("R4 no exchange while disabled", v, 0);
        check("R4 irq while disabled", irq, 0);
    endtask

    // Bench acts as master; 8-clock half-periods on the external clock.
    task automatic t_slave(input logic [7:0] ctl, input logic [7:0] pre,
                           input logic [7:0] mtx, input bit use_ss,
                           input logic [7:0] old_rx);
        logic lsb = ctl[5], cph = ctl[2], sel;
        logic [7:0] got = 8'h00, v;
        int ns = 0;
        sel = use_ss || ctl[7];
        sck_i = ctl[3]; ss_n_i = 1'b1;
        wr(2'd0, ctl);
        wr(2'd1, 8'hC0);
        wr(2'd2, pre);
        repeat (4) @(negedge clk);
        check("R3 slave clock and mosi enables", {sck_oe, mosi_oe}, 0);
        if (use_ss) ss_n_i = 1'b0;
        if (cph == 1'b0) mosi_i = bitof(mtx, 0, lsb);
        repeat (8) @(negedge clk);
        check("R7 miso enable vs select", miso_oe, sel);
        for (int e = 1; e <= 16; e++) begin
            sck_i = ~sck_i;
            if (((e % 2) == 1) == (cph == 1'b0)) begin
                if (ns < 8) got = setbit(got, ns, lsb, miso_o);
                ns++;
            end else if (ns < 8) begin
                mosi_i = bitof(mtx, ns, lsb);
            end
            repeat (8) @(negedge clk);
        end
        rd(2'd1, v);
        check("R12 R7 slave completion flag", v[7], sel);
        rd(2'd2, v);
        check("R12 R8 slave received byte", v, sel ? mtx : old_rx);
        if (sel) check("R12 R9 R11 slave sent byte", got, pre);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        if (!ctl[7]) check("R7 miso released after deselect", miso_oe, 0);
        wr(2'd1, 8'hC0);
    endtask

    task automatic t_slave_abort();
        logic [7:0] v;
        sck_i = 1'b0; ss_n_i = 1'b1;
        wr(2'd0, C_EN);
        wr(2'd1, 8'hC0);
        wr(2'd2, 8'hF0);
        repeat (4) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int e = 1; e <= 6; e++) begin
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
        end
        ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
        rd(2'd1, v); check("R13 no completion after abort", v, 0);
        t_slave(C_EN, 8'h2D, 8'h74, 1'b1, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master(C_EN | C_MST | 8'h00,                  8'hA5, 8'h3C, 0);
        t_master(C_EN | C_MST | C_CPOL | C_CPHA | C_LSB | 8'h01, 8'h81, 8'h7E, 0);
        t_master(C_EN | C_MST | C_CPHA | 8'h02,         8'h96, 8'h0F, 0);
        t_master(C_EN | C_MST | C_CPOL | C_LSB | 8'h03, 8'h1E, 8'hE1, 0);
        t_master(C_EN | C_MST | 8'h01,                  8'hC3, 8'h55, 20);
        t_disabled();
        t_slave(C_EN, 8'h6B, 8'hD2, 1'b1, 8'h00);
        t_slave(C_EN | C_CPHA | C_CPOL | C_LSB, 8'h35, 8'h9A, 1'b1, 8'h00);
        t_slave(C_EN, 8'h11, 8'h22, 1'b0, 8'h9A);
        t_slave(C_EN | C_SSIG, 8'h47, 8'hB8, 1'b0, 8'h00);
        t_slave_abort();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule